// File: doc/BRIEF.md
# Microring Wavelength Lock Controller

This block brings a row of microring filters onto their wavelengths, one ring after another, and then keeps each one there. For every ring it drives a 14-bit heater code and reads a 14-bit photodetector sample. A channel that has been started searches by stepping its heater word upward like a slow ramp. A square dither of fixed amplitude is added on top of that word. The channel demodulates its samples against the dither to form an error value once per dither period.

When the error value rises above that ring's own trip level, the channel stops the ramp and keeps the word it has reached. It raises its locked flag and switches to proportional-integral tracking of that ring's own hold reference. The lock of one ring starts the search of the next ring. If a ramp reaches its top without finding the ring, the channel flags a failure and falls back to idle, and the rings after it are never started.

Top module: `ring_lock_ctrl`

## Requirements
- R1: After reset every channel is idle with heater code 0 and its locked and fail flags clear. An idle channel always drives code 0.
- R2: A start pulse is accepted only when every channel is idle. It sends ring 0 into its search with word 0 and clears that ring's fail flag. During the search the word rises by one every RAMP_DIV clocks.
- R3: The dither is a square wave of 2*DITHER_HALF clocks, low half first after reset. An active channel drives word+DITHER_AMP in the high half and the plain word in the low half, clamped to 16383.
- R4: Over each dither period, each channel's error value equals the sum of its valid samples (unsigned 14-bit) taken in the high half minus the sum of those taken in the low half. The value is presented once, when the period ends.
- R5: A searching channel whose error value is strictly greater than its own trip level keeps its current word, sets locked, and begins tracking.
- R6: Ring i+1 begins its search from word 0 in the same clock that ring i locks, and never drives a nonzero code before ring i is locked.
- R7: While tracking, on each error value the channel forms e = error − hold reference and n = integrator + e. The new word is lock word + (e >>> KP_SH) + (n >>> KI_SH), with arithmetic shifts. When this word is in range, n becomes the new integrator value.
- R8: A tracking word below 0 or above 16383 is clamped to that limit, and in that update the integrator keeps its old value.
- R9: A search that would step past RAMP_TOP instead sets the channel's fail flag, leaves locked clear and returns the channel to idle with code 0.
- R10: A start pulse while any channel is searching or tracking has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the sequential lock sequence |
| adc_valid | input | 1 | Sample strobe shared by all channels |
| adc_sample | input | N_RING*14 | Photodetector sample per ring, ring 0 in the low bits |
| dac_code | output | N_RING*14 | Heater code per ring, ring 0 in the low bits |
| locked | output | N_RING | Ring is tracking its resonance |
| fail | output | N_RING | Ring search ended at the ramp top without a lock |

## Verification
The hardest state to reach is a tracking channel that sits at the code ceiling. Normal resonance feedback never drives it there. The bench switches the ring's plant to a sample that follows the dither phase, which produces a large positive error every period. This pushes the word into the clamp and holds it there for several periods. The plant is then reversed, and the bench checks that the word leaves the ceiling on the next full update; a wound-up integrator would keep it pinned. The ramp failure is reached by leaving one ring's resonance out of the plant, and restart after a failure is covered by removing ring 0.

// File: rtl/rl_pkg.sv
// Shared types for the ring lock controller.
// Assumes: one state register per channel; encodings are local to this block.
package rl_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_SWEEP = 2'd1,
        CH_TRACK = 2'd2
    } ch_state_t;
endpackage

// File: rtl/rl_dither.sv
// Square dither phase generator shared by all channels.
// Assumes: HALF >= 1 clocks per half period; low half comes first after reset.
module rl_dither #(
    parameter int HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic hi,
    output logic period_end
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          last;

    assign last       = (cnt == CW'(HALF - 1));
    assign period_end = last && hi;

    // Count clocks in the half period and flip the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else if (last) begin
            cnt <= '0;
            hi  <= ~hi;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rl_demod.sv
// Synchronous demodulator for one ring: signed sum of samples over a dither period.
// Assumes: samples are unsigned DW-bit; ACCW is wide enough for 2*HALF full-scale samples.
module rl_demod #(
    parameter int DW   = 14,
    parameter int ACCW = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hi,
    input  logic                   period_end,
    input  logic                   vld,
    input  logic [DW-1:0]          sample,
    output logic signed [ACCW-1:0] err,
    output logic                   err_vld
);
    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] s_ext;
    logic signed [ACCW-1:0] contrib;

    assign s_ext   = $signed(ACCW'(sample));
    assign contrib = !vld ? '0 : (hi ? s_ext : -s_ext);

    // Accumulate with the dither sign and publish the result at period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            err     <= '0;
            err_vld <= 1'b0;
        end else if (period_end) begin
            err     <= acc + contrib;
            err_vld <= 1'b1;
            acc     <= '0;
        end else begin
            acc     <= acc + contrib;
            err_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/rl_chan.sv
// One ring channel: ramp search, threshold handover, clamped PI tracking.
// Assumes: err_vld pulses once per dither period; TRIP and HOLD are per-ring constants.
module rl_chan
    import rl_pkg::*;
#(
    parameter int                 DW       = 14,
    parameter int                 ACCW     = 20,
    parameter int                 RAMP_DIV = 4,
    parameter int                 RAMP_TOP = 16319,
    parameter int                 AMP      = 64,
    parameter int                 KP_SH    = 4,
    parameter int                 KI_SH    = 6,
    parameter logic signed [31:0] TRIP     = 32'sd2000,
    parameter logic signed [31:0] HOLD     = 32'sd0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go,
    input  logic                   dith_hi,
    input  logic                   err_vld,
    input  logic signed [ACCW-1:0] err,
    output logic [DW-1:0]          code,
    output logic [DW-1:0]          word,
    output logic                   locked,
    output logic                   fail,
    output logic                   busy,
    output logic                   ramping,
    output logic                   lock_hit
);
    localparam int WW   = ACCW + DW + 4;
    localparam int DIVW = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;
    localparam logic signed [WW-1:0] CMAX_W = WW'((1 << DW) - 1);

    ch_state_t            st;
    logic [DIVW-1:0]      div;
    logic [DW-1:0]        base;
    logic signed [WW-1:0] integ;
    logic signed [WW-1:0] err_w, trip_w, hold_w, base_w, e_w, ni_w, u_w;
    logic [DW:0]          sum;

    assign busy     = (st != CH_IDLE);
    assign ramping  = (st == CH_SWEEP);

    // Widen the operands and form the trip test and the PI candidate.
    always_comb begin
        err_w    = WW'(err);
        trip_w   = WW'(TRIP);
        hold_w   = WW'(HOLD);
        base_w   = $signed(WW'(base));
        lock_hit = ramping && err_vld && (err_w > trip_w);
        e_w      = err_w - hold_w;
        ni_w     = integ + e_w;
        u_w      = base_w + (e_w >>> KP_SH) + (ni_w >>> KI_SH);
    end

    // Heater code: word plus dither in the high half, clamped; zero when idle.
    always_comb begin
        sum  = {1'b0, word} + (dith_hi ? (DW+1)'(AMP) : '0);
        code = !busy ? '0 : (sum[DW] ? '1 : sum[DW-1:0]);
    end

    // Channel sequencing: idle, ramp search, tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= CH_IDLE;
            word   <= '0;
            base   <= '0;
            integ  <= '0;
            div    <= '0;
            locked <= 1'b0;
            fail   <= 1'b0;
        end else begin
            case (st)
                CH_IDLE: begin
                    if (go) begin
                        st     <= CH_SWEEP;
                        word   <= '0;
                        div    <= '0;
                        fail   <= 1'b0;
                        locked <= 1'b0;
                    end
                end
                CH_SWEEP: begin
                    if (lock_hit) begin
                        st     <= CH_TRACK;
                        base   <= word;
                        integ  <= '0;
                        locked <= 1'b1;
                    end else if (div == DIVW'(RAMP_DIV - 1)) begin
                        div <= '0;
                        if (word == DW'(RAMP_TOP)) begin
                            st   <= CH_IDLE;
                            fail <= 1'b1;
                            word <= '0;
                        end else begin
                            word <= word + 1'b1;
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                CH_TRACK: begin
                    if (err_vld) begin
                        if (u_w < 0) begin
                            word <= '0;
                        end else if (u_w > CMAX_W) begin
                            word <= '1;
                        end else begin
                            word  <= u_w[DW-1:0];
                            integ <= ni_w;
                        end
                    end
                end
                default: st <= CH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ring_lock_ctrl.sv
// Top: shared dither, one demodulator and one channel per ring, sequential start chain.
// Assumes: per-ring constants packed 32 bits per ring, ring 0 in the low word.
module ring_lock_ctrl #(
    parameter int                      N_RING      = 2,
    parameter int                      DW          = 14,
    parameter int                      DITHER_HALF = 8,
    parameter int                      DITHER_AMP  = 64,
    parameter int                      RAMP_DIV    = 4,
    parameter int                      RAMP_TOP    = (1 << DW) - 1 - DITHER_AMP,
    parameter int                      KP_SH       = 4,
    parameter int                      KI_SH       = 6,
    parameter logic [N_RING*32-1:0]    TRIP_LVL    = {32'd2500, 32'd2000},
    parameter logic [N_RING*32-1:0]    HOLD_REF    = {32'd40, 32'd0}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 adc_valid,
    input  logic [N_RING*DW-1:0] adc_sample,
    output logic [N_RING*DW-1:0] dac_code,
    output logic [N_RING-1:0]    locked,
    output logic [N_RING-1:0]    fail
);
    localparam int ACCW = DW + $clog2(2 * DITHER_HALF) + 2;

    logic                   hi, period_end;
    logic [N_RING-1:0]      go, busy_v, ramp_v, lock_hit;
    logic [N_RING*DW-1:0]   word_flat;

    rl_dither #(.HALF(DITHER_HALF)) u_dith (
        .clk(clk), .rst_n(rst_n), .hi(hi), .period_end(period_end)
    );

    for (genvar i = 0; i < N_RING; i++) begin : g_ring
        logic signed [ACCW-1:0] err;
        logic                   err_vld;

        // Ring 0 starts on an accepted start; later rings start on the previous lock.
        if (i == 0) begin : g_first
            assign go[i] = start && !(|busy_v);
        end else begin : g_next
            assign go[i] = lock_hit[i-1];
        end

        rl_demod #(.DW(DW), .ACCW(ACCW)) u_dem (
            .clk(clk), .rst_n(rst_n), .hi(hi), .period_end(period_end),
            .vld(adc_valid), .sample(adc_sample[i*DW +: DW]),
            .err(err), .err_vld(err_vld)
        );

        rl_chan #(
            .DW(DW), .ACCW(ACCW), .RAMP_DIV(RAMP_DIV), .RAMP_TOP(RAMP_TOP),
            .AMP(DITHER_AMP), .KP_SH(KP_SH), .KI_SH(KI_SH),
            .TRIP($signed(TRIP_LVL[i*32 +: 32])),
            .HOLD($signed(HOLD_REF[i*32 +: 32]))
        ) u_ch (
            .clk(clk), .rst_n(rst_n), .go(go[i]), .dith_hi(hi),
            .err_vld(err_vld), .err(err),
            .code(dac_code[i*DW +: DW]), .word(word_flat[i*DW +: DW]),
            .locked(locked[i]), .fail(fail[i]), .busy(busy_v[i]),
            .ramping(ramp_v[i]), .lock_hit(lock_hit[i])
        );
    end
endmodule

// File: rtl/rl_check.sv
// Property checker for ring_lock_ctrl, attached by bind.
// Assumes: internal vectors of the top are visible by name at the bind site.
module rl_check #(
    parameter int N_RING = 2,
    parameter int DW     = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_RING*DW-1:0] dac_code,
    input logic [N_RING*DW-1:0] word_flat,
    input logic [N_RING-1:0]    locked,
    input logic [N_RING-1:0]    fail,
    input logic [N_RING-1:0]    busy_v,
    input logic [N_RING-1:0]    ramp_v,
    input logic [N_RING-1:0]    lock_hit
);
    for (genvar i = 0; i < N_RING; i++) begin : g_chk
        // R1
        idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !busy_v[i] |-> dac_code[i*DW +: DW] == '0);

        // R5
        lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lock_hit[i] |=> locked[i] && word_flat[i*DW +: DW] == $past(word_flat[i*DW +: DW]));

        // R9
        fail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fail[i]) |-> !busy_v[i] && !locked[i] && dac_code[i*DW +: DW] == '0);

        // R9
        flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(locked[i] && fail[i]));

        if (i > 0) begin : g_ord
            // R6
            order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ramp_v[i] |-> locked[i-1]);
        end
    end
endmodule

bind ring_lock_ctrl rl_check #(.N_RING(N_RING), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dac_code(dac_code), .word_flat(word_flat),
    .locked(locked), .fail(fail), .busy_v(busy_v), .ramp_v(ramp_v),
    .lock_hit(lock_hit)
);

// File: tb/sim_ring_lock_ctrl.sv
// Bench: behavioural per-cycle model plus a simple resonance plant per ring.
module sim_ring_lock_ctrl;
    localparam int  N = 2, DW = 14, HALF = 8, AMP = 64, RDIV = 1, RTOP = 2000;
    localparam int  KP = 4, KI = 6;
    localparam longint MAXC = 16383;
    longint thr [2] = '{2000, 2500};
    longint hold[2] = '{0, 40};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              adc_valid = 1'b0;
    logic [N*DW-1:0]   adc_sample = '0;
    logic [N*DW-1:0]   dac_code;
    logic [N-1:0]      locked, fail;

    always #10 clk = ~clk;

    ring_lock_ctrl #(
        .N_RING(N), .DW(DW), .DITHER_HALF(HALF), .DITHER_AMP(AMP),
        .RAMP_DIV(RDIV), .RAMP_TOP(RTOP), .KP_SH(KP), .KI_SH(KI),
        .TRIP_LVL({32'd2500, 32'd2000}), .HOLD_REF({32'd40, 32'd0})
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .adc_valid(adc_valid),
        .adc_sample(adc_sample), .dac_code(dac_code), .locked(locked), .fail(fail)
    );

    int total = 0, bad = 0, cyc = 0;
    bit done = 1'b0, start_req = 1'b0;
    string note = "";

    // model state
    longint m_acc[2], m_err[2], m_word[2], m_base[2], m_integ[2];
    bit     m_ev[2], m_lk[2], m_fl[2];
    int     m_st[2], m_div[2], m_cnt;
    bit     m_ph;
    int     res[2], pmode[2];

    function automatic longint mcode(int i);
        longint v;
        if (m_st[i] == 0) return 0;
        v = m_word[i] + (m_ph ? AMP : 0);
        return (v > MAXC) ? MAXC : v;
    endfunction

    function automatic longint plant(int i);
        longint d, v;
        if (pmode[i] == 1) return m_ph ? 4000 : 0;
        if (pmode[i] == 2) return m_ph ? 0 : 4000;
        d = mcode(i) - res[i];
        if (d < 0) d = -d;
        v = 4000 - 20 * d;
        return (v < 0) ? 0 : v;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", req, note, cyc, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_acc[i] = 0; m_err[i] = 0; m_word[i] = 0; m_base[i] = 0; m_integ[i] = 0;
            m_ev[i] = 0; m_lk[i] = 0; m_fl[i] = 0; m_st[i] = 0; m_div[i] = 0;
        end
        m_cnt = 0; m_ph = 0;
    endtask

    task automatic model_step(bit st_in, bit v_in, longint s0, longint s1);
        bit hit[2], go[2], pend;
        longint s[2], e, ni, u, c;
        s[0] = s0; s[1] = s1;
        for (int i = 0; i < 2; i++) hit[i] = (m_st[i] == 1) && m_ev[i] && (m_err[i] > thr[i]);
        go[0] = st_in && m_st[0] == 0 && m_st[1] == 0;
        go[1] = hit[0];
        pend = (m_cnt == HALF - 1) && m_ph;
        for (int i = 0; i < 2; i++) begin
            case (m_st[i])
                0: if (go[i]) begin m_st[i] = 1; m_word[i] = 0; m_div[i] = 0; m_fl[i] = 0; m_lk[i] = 0; end
                1: if (hit[i]) begin
                        m_st[i] = 2; m_base[i] = m_word[i]; m_integ[i] = 0; m_lk[i] = 1;
                    end else if (m_div[i] == RDIV - 1) begin
                        m_div[i] = 0;
                        if (m_word[i] == RTOP) begin m_st[i] = 0; m_fl[i] = 1; m_word[i] = 0; end
                        else m_word[i]++;
                    end else m_div[i]++;
                default: if (m_ev[i]) begin
                        e = m_err[i] - hold[i];
                        ni = m_integ[i] + e;
                        u = m_base[i] + (e >>> KP) + (ni >>> KI);
                        if (u < 0) m_word[i] = 0;
                        else if (u > MAXC) m_word[i] = MAXC;
                        else begin m_word[i] = u; m_integ[i] = ni; end
                    end
            endcase
            c = v_in ? (m_ph ? s[i] : -s[i]) : 0;
            if (pend) begin m_err[i] = m_acc[i] + c; m_ev[i] = 1; m_acc[i] = 0; end
            else begin m_acc[i] = m_acc[i] + c; m_ev[i] = 0; end
        end
        if (m_cnt == HALF - 1) begin m_cnt = 0; m_ph = !m_ph; end
        else m_cnt++;
    endtask

    // One clock: compare at the falling edge, drive inputs, advance the model.
    task automatic tick();
        longint s0, s1;
        string t;
        for (int i = 0; i < 2; i++) begin
            if (m_st[i] == 0) t = "R1";
            else if (m_ph) t = "R3";
            else if (m_st[i] == 1) t = "R2";
            else if (m_word[i] == MAXC || m_word[i] == 0) t = "R8";
            else t = "R7";
            chk(dac_code[i*DW +: DW] == mcode(i), t, dac_code[i*DW +: DW], mcode(i));
            chk(locked[i] == m_lk[i], "R4/R5", locked[i], m_lk[i]);
            chk(fail[i] == m_fl[i], "R9", fail[i], m_fl[i]);
        end
        if (!m_lk[0]) chk(dac_code[DW +: DW] == 0, "R6", dac_code[DW +: DW], 0);
        s0 = plant(0); s1 = plant(1);
        adc_valid  = cyc[0];
        adc_sample = {DW'(s1), DW'(s0)};
        start      = start_req;
        model_step(start_req, cyc[0], s0, s1);
        start_req  = 0;
        cyc++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; start = 0; adc_valid = 0; adc_sample = '0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1;
        for (int i = 0; i < 2; i++) begin
            chk(dac_code[i*DW +: DW] == 0, "R1", dac_code[i*DW +: DW], 0);
            chk(locked[i] == 0 && fail[i] == 0, "R1", {locked[i], fail[i]}, 0);
        end
    endtask

    task automatic run_until_lock(int i, int lim);
        for (int n = 0; n < lim && !m_lk[i]; n++) tick();
        chk(locked[i] == 1, "R5", locked[i], 1);
    endtask

    task automatic run_until_fail(int i, int lim);
        for (int n = 0; n < lim && !m_fl[i]; n++) tick();
        chk(fail[i] == 1, "R9", fail[i], 1);
        chk(dac_code[i*DW +: DW] == 0, "R9", dac_code[i*DW +: DW], 0);
        chk(locked[i] == 0, "R9", locked[i], 0);
    endtask

    initial begin
        @(negedge clk);
        // Scenario 1: both rings present, sequential lock, then saturation.
        res[0] = 300; res[1] = 700; pmode[0] = 0; pmode[1] = 0;
        do_reset();
        repeat (20) tick();
        note = "start";
        start_req = 1; tick();
        run_until_lock(0, 3000);
        note = "ring0 lock";
        chk(locked[1] == 0, "R6", locked[1], 0);
        run_until_lock(1, 5000);
        repeat (200) tick();
        note = "start while tracking";
        start_req = 1;
        repeat (40) tick();
        chk(locked == 2'b11 && fail == 2'b00, "R10", {locked, fail}, 4'b1100);
        note = "drive to ceiling";
        pmode[0] = 1;
        for (int n = 0; n < 3000 && m_word[0] != MAXC; n++) tick();
        repeat (100) tick();
        while (m_ph) tick();
        chk(dac_code[0 +: DW] == MAXC, "R8", dac_code[0 +: DW], MAXC);
        note = "reverse";
        pmode[0] = 2;
        repeat (52) tick();
        while (m_ph) tick();
        chk(dac_code[0 +: DW] < MAXC, "R8", dac_code[0 +: DW], MAXC - 1);
        repeat (64) tick();

        // Scenario 2: ring 1 absent, ramp runs out; start stays ignored.
        note = "ring1 absent";
        res[0] = 300; res[1] = -100000; pmode[0] = 0; pmode[1] = 0;
        do_reset();
        start_req = 1; tick();
        run_until_lock(0, 3000);
        run_until_fail(1, 5000);
        start_req = 1;
        repeat (50) tick();
        chk(fail[1] == 1 && dac_code[DW +: DW] == 0, "R10", {fail[1], dac_code[DW +: DW]}, 1 << DW);

        // Scenario 3: ring 0 absent, failure, then restart accepted.
        note = "ring0 absent";
        res[0] = -100000; res[1] = 700;
        do_reset();
        start_req = 1; tick();
        run_until_fail(0, 5000);
        chk(dac_code[DW +: DW] == 0, "R6", dac_code[DW +: DW], 0);
        repeat (10) tick();
        note = "restart";
        start_req = 1;
        repeat (30) tick();
        chk(fail[0] == 0, "R2", fail[0], 0);
        while (!m_ph) tick();
        chk(dac_code[0 +: DW] >= AMP, "R2", dac_code[0 +: DW], AMP);
        repeat (20) tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R5 watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule